// File: doc/BRIEF.md
# Staged pipeline control register

This block carries the control word of a five-stage in-order datapath from the decode stage down to the stages that consume it. The main decoder presents a full control bundle in decode, together with a three-bit instruction class and a bubble request. The block registers that bundle through three stage boundaries. It then drives the execute group one cycle later, the memory group two cycles later and the writeback group three cycles later, so that each group arrives together with its own instruction.

Before the first register, the block clears the groups that the instruction class does not use. R-type operations pass through an idle memory stage and write the register file in stage five, the same stage as loads, so the single write port never sees two writers. Stores leave writeback idle. Branches leave both memory and writeback idle. A bubble request, or a class code outside the four defined ones, turns the whole slot into an all-zero control word. That word moves down the pipe like any other instruction and does not disturb the instructions ahead of it.

Top module: `pctl_pipe`

## Requirements
- R1: A synchronous active-high reset clears every stage register, so all outputs read zero in the cycle after the reset edge.
- R2: The execute group (ALU operation, two source selects, destination select) captured at a rising edge drives the execute outputs from that edge on, which is exactly one cycle after decode.
- R3: The memory group (memory write enable, address source select) reaches the memory outputs after the second rising edge following decode.
- R4: The writeback group (memory-to-register select, register write enable) reaches the writeback outputs after the third rising edge following decode.
- R5: Class code 1 (R-type) passes its execute and writeback groups and forces its memory group to zero.
- R6: Class code 2 (load) passes all three groups unchanged.
- R7: Class code 3 (store) passes its execute and memory groups and forces its writeback group to zero.
- R8: Class code 4 (branch) passes its execute group and forces its memory and writeback groups to zero.
- R9: With the bubble request high, every group of that slot is zero whatever the class and field values. Instructions already in flight still reach their own stages.
- R10: Class codes 0, 5, 6 and 7 act as a bubble: every group of that slot is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| d_alu_op | input | 4 | Decoded ALU operation |
| d_src_a | input | 1 | Decoded ALU source A select |
| d_src_b | input | 1 | Decoded ALU source B select |
| d_dst_sel | input | 1 | Decoded destination register select |
| d_mem_we | input | 1 | Decoded data memory write enable |
| d_addr_sel | input | 1 | Decoded memory address source select |
| d_mem_to_reg | input | 1 | Decoded writeback source select |
| d_reg_we | input | 1 | Decoded register file write enable |
| d_class | input | 3 | Instruction class: 1 R-type, 2 load, 3 store, 4 branch, others bubble |
| d_bubble | input | 1 | Insert an all-zero control word in this slot |
| ex_alu_op | output | 4 | ALU operation for the execute stage |
| ex_src_a | output | 1 | ALU source A select for the execute stage |
| ex_src_b | output | 1 | ALU source B select for the execute stage |
| ex_dst_sel | output | 1 | Destination select for the execute stage |
| mem_we | output | 1 | Data memory write enable for the memory stage |
| mem_addr_sel | output | 1 | Address source select for the memory stage |
| wb_mem_to_reg | output | 1 | Writeback source select for stage five |
| wb_reg_we | output | 1 | Register file write enable for stage five |

## Verification
A decode slot is sampled at one rising edge. Its execute group is due after that edge, its memory group one edge later and its writeback group one edge after that. The bench drives each slot on a falling edge and compares the outputs on the next falling edge. At that point the execute outputs must match the slot just issued, the memory outputs the slot before it and the writeback outputs the slot two back. The expected words move through a three-deep history in the bench, and a mid-run reset clears all three entries at once. The bound checker states the same one, two and three cycle offsets with $past depths fixed at 1, 2 and 3.

// File: rtl/pctl_pkg.sv
package pctl_pkg;

    localparam int ALUOP_W = 4;
    localparam int CLASS_W = 3;

    typedef enum logic [CLASS_W-1:0] {
        CLS_NONE   = 3'd0,
        CLS_RTYPE  = 3'd1,
        CLS_LOAD   = 3'd2,
        CLS_STORE  = 3'd3,
        CLS_BRANCH = 3'd4
    } iclass_e;

    typedef struct packed {
        logic [ALUOP_W-1:0] alu_op;
        logic               src_a;
        logic               src_b;
        logic               dst_sel;
    } ex_ctl_t;

    typedef struct packed {
        logic we;
        logic addr_sel;
    } mem_ctl_t;

    typedef struct packed {
        logic mem_to_reg;
        logic reg_we;
    } wb_ctl_t;

    typedef struct packed {
        mem_ctl_t mem;
        wb_ctl_t  wb;
    } late_ctl_t;

    typedef struct packed {
        ex_ctl_t   ex;
        late_ctl_t late;
    } ctl_bundle_t;

    localparam int BUNDLE_W = $bits(ctl_bundle_t);
    localparam int LATE_W   = $bits(late_ctl_t);
    localparam int WB_W     = $bits(wb_ctl_t);

    function automatic logic uses_ex(logic [CLASS_W-1:0] cls);
        return (cls == CLS_RTYPE) || (cls == CLS_LOAD) ||
               (cls == CLS_STORE) || (cls == CLS_BRANCH);
    endfunction

    function automatic logic uses_mem(logic [CLASS_W-1:0] cls);
        return (cls == CLS_LOAD) || (cls == CLS_STORE);
    endfunction

    function automatic logic uses_wb(logic [CLASS_W-1:0] cls);
        return (cls == CLS_RTYPE) || (cls == CLS_LOAD);
    endfunction

endpackage

// File: rtl/pctl_slot_filter.sv
module pctl_slot_filter
    import pctl_pkg::*;
(
    input  ctl_bundle_t          raw_i,
    input  logic [CLASS_W-1:0]   cls_i,
    input  logic                 bubble_i,
    output ctl_bundle_t          slot_o
);

    logic keep_ex;
    logic keep_mem;
    logic keep_wb;

    always_comb begin
        keep_ex  = !bubble_i && uses_ex(cls_i);
        keep_mem = !bubble_i && uses_mem(cls_i);
        keep_wb  = !bubble_i && uses_wb(cls_i);

        slot_o = '0;
        if (keep_ex)  slot_o.ex       = raw_i.ex;
        if (keep_mem) slot_o.late.mem = raw_i.late.mem;
        if (keep_wb)  slot_o.late.wb  = raw_i.late.wb;
    end

endmodule

// File: rtl/pctl_stage_reg.sv
module pctl_stage_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

endmodule

// File: rtl/pctl_pipe.sv
module pctl_pipe
    import pctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [ALUOP_W-1:0] d_alu_op,
    input  logic               d_src_a,
    input  logic               d_src_b,
    input  logic               d_dst_sel,
    input  logic               d_mem_we,
    input  logic               d_addr_sel,
    input  logic               d_mem_to_reg,
    input  logic               d_reg_we,
    input  logic [CLASS_W-1:0] d_class,
    input  logic               d_bubble,
    output logic [ALUOP_W-1:0] ex_alu_op,
    output logic               ex_src_a,
    output logic               ex_src_b,
    output logic               ex_dst_sel,
    output logic               mem_we,
    output logic               mem_addr_sel,
    output logic               wb_mem_to_reg,
    output logic               wb_reg_we
);

    ctl_bundle_t raw_b;
    ctl_bundle_t slot_b;

    logic [BUNDLE_W-1:0] idex_q;
    logic [LATE_W-1:0]   exmem_q;
    logic [WB_W-1:0]     memwb_q;

    ctl_bundle_t idex_b;
    late_ctl_t   exmem_b;
    wb_ctl_t     memwb_b;

    always_comb begin
        raw_b.ex.alu_op          = d_alu_op;
        raw_b.ex.src_a           = d_src_a;
        raw_b.ex.src_b           = d_src_b;
        raw_b.ex.dst_sel         = d_dst_sel;
        raw_b.late.mem.we        = d_mem_we;
        raw_b.late.mem.addr_sel  = d_addr_sel;
        raw_b.late.wb.mem_to_reg = d_mem_to_reg;
        raw_b.late.wb.reg_we     = d_reg_we;
    end

    pctl_slot_filter u_filter (
        .raw_i    (raw_b),
        .cls_i    (d_class),
        .bubble_i (d_bubble),
        .slot_o   (slot_b)
    );

    pctl_stage_reg #(.WIDTH(BUNDLE_W)) u_id_ex (
        .clk (clk),
        .rst (rst),
        .d   (slot_b),
        .q   (idex_q)
    );
    assign idex_b = idex_q;

    pctl_stage_reg #(.WIDTH(LATE_W)) u_ex_mem (
        .clk (clk),
        .rst (rst),
        .d   (idex_b.late),
        .q   (exmem_q)
    );
    assign exmem_b = exmem_q;

    pctl_stage_reg #(.WIDTH(WB_W)) u_mem_wb (
        .clk (clk),
        .rst (rst),
        .d   (exmem_b.wb),
        .q   (memwb_q)
    );
    assign memwb_b = memwb_q;

    assign ex_alu_op     = idex_b.ex.alu_op;
    assign ex_src_a      = idex_b.ex.src_a;
    assign ex_src_b      = idex_b.ex.src_b;
    assign ex_dst_sel    = idex_b.ex.dst_sel;
    assign mem_we        = exmem_b.mem.we;
    assign mem_addr_sel  = exmem_b.mem.addr_sel;
    assign wb_mem_to_reg = memwb_b.mem_to_reg;
    assign wb_reg_we     = memwb_b.reg_we;

endmodule

// File: rtl/pctl_pipe_chk.sv
module pctl_pipe_chk
    import pctl_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [ALUOP_W-1:0] d_alu_op,
    input logic               d_src_a,
    input logic               d_src_b,
    input logic               d_dst_sel,
    input logic               d_mem_we,
    input logic               d_addr_sel,
    input logic               d_mem_to_reg,
    input logic               d_reg_we,
    input logic [CLASS_W-1:0] d_class,
    input logic               d_bubble,
    input logic [ALUOP_W-1:0] ex_alu_op,
    input logic               ex_src_a,
    input logic               ex_src_b,
    input logic               ex_dst_sel,
    input logic               mem_we,
    input logic               mem_addr_sel,
    input logic               wb_mem_to_reg,
    input logic               wb_reg_we
);

    localparam int EXG_W = ALUOP_W + 3;

    logic [1:0] since_rst;
    logic       go_ex, go_mem, go_wb;
    logic [EXG_W-1:0] in_ex, out_ex;
    logic [1:0] in_mem, out_mem, in_wb, out_wb;

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assign go_ex  = !d_bubble && (d_class >= 3'd1) && (d_class <= 3'd4);
    assign go_mem = !d_bubble && (d_class == 3'd2 || d_class == 3'd3);
    assign go_wb  = !d_bubble && (d_class == 3'd1 || d_class == 3'd2);

    assign in_ex   = {d_alu_op, d_src_a, d_src_b, d_dst_sel};
    assign out_ex  = {ex_alu_op, ex_src_a, ex_src_b, ex_dst_sel};
    assign in_mem  = {d_mem_we, d_addr_sel};
    assign out_mem = {mem_we, mem_addr_sel};
    assign in_wb   = {d_mem_to_reg, d_reg_we};
    assign out_wb  = {wb_mem_to_reg, wb_reg_we};

    // R1
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_ex == '0 && out_mem == '0 && out_wb == '0));

    // R2
    a_r2_ex_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd1) |->
            (out_ex == ($past(go_ex) ? $past(in_ex) : '0)));

    // R3
    a_r3_mem_two_cycles: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |->
            (out_mem == ($past(go_mem, 2) ? $past(in_mem, 2) : 2'b00)));

    // R4
    a_r4_wb_three_cycles: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |->
            (out_wb == ($past(go_wb, 3) ? $past(in_wb, 3) : 2'b00)));

    // R5
    a_r5_rtype_idle_mem: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && $past(d_class, 2) == 3'd1) |-> !mem_we);

    // R8
    a_r8_branch_idle_wb: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && $past(d_class, 3) == 3'd4) |-> !wb_reg_we);

    // R9
    a_r9_bubble_zero_ex: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd1 && $past(d_bubble)) |-> (out_ex == '0));

endmodule

bind pctl_pipe pctl_pipe_chk u_pctl_pipe_chk (
    .clk           (clk),
    .rst           (rst),
    .d_alu_op      (d_alu_op),
    .d_src_a       (d_src_a),
    .d_src_b       (d_src_b),
    .d_dst_sel     (d_dst_sel),
    .d_mem_we      (d_mem_we),
    .d_addr_sel    (d_addr_sel),
    .d_mem_to_reg  (d_mem_to_reg),
    .d_reg_we      (d_reg_we),
    .d_class       (d_class),
    .d_bubble      (d_bubble),
    .ex_alu_op     (ex_alu_op),
    .ex_src_a      (ex_src_a),
    .ex_src_b      (ex_src_b),
    .ex_dst_sel    (ex_dst_sel),
    .mem_we        (mem_we),
    .mem_addr_sel  (mem_addr_sel),
    .wb_mem_to_reg (wb_mem_to_reg),
    .wb_reg_we     (wb_reg_we)
);

// File: tb/pctl_pipe_test.sv
module pctl_pipe_test;

    localparam int CLK_PERIOD = 10;
    localparam int SLOTS      = 320;
    localparam int RESET_SLOT = 150;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] d_alu_op = '0;
    logic       d_src_a = 1'b0, d_src_b = 1'b0, d_dst_sel = 1'b0;
    logic       d_mem_we = 1'b0, d_addr_sel = 1'b0;
    logic       d_mem_to_reg = 1'b0, d_reg_we = 1'b0;
    logic [2:0] d_class = '0;
    logic       d_bubble = 1'b0;

    logic [3:0] ex_alu_op;
    logic       ex_src_a, ex_src_b, ex_dst_sel;
    logic       mem_we, mem_addr_sel, wb_mem_to_reg, wb_reg_we;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pctl_pipe uut (
        .clk(clk), .rst(rst),
        .d_alu_op(d_alu_op), .d_src_a(d_src_a), .d_src_b(d_src_b),
        .d_dst_sel(d_dst_sel), .d_mem_we(d_mem_we), .d_addr_sel(d_addr_sel),
        .d_mem_to_reg(d_mem_to_reg), .d_reg_we(d_reg_we),
        .d_class(d_class), .d_bubble(d_bubble),
        .ex_alu_op(ex_alu_op), .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
        .ex_dst_sel(ex_dst_sel), .mem_we(mem_we), .mem_addr_sel(mem_addr_sel),
        .wb_mem_to_reg(wb_mem_to_reg), .wb_reg_we(wb_reg_we)
    );

    // word layout: [10:4] execute group, [3:2] memory group, [1:0] writeback group
    logic [10:0] e1 = '0, e2 = '0, e3 = '0;
    string       t1 = "R1", t2 = "R1", t3 = "R1";

    function automatic logic [10:0] expect_word(logic [2:0] cls, logic bub, logic [10:0] raw);
        logic [10:0] w;
        w = '0;
        if (!bub && cls >= 3'd1 && cls <= 3'd4) begin
            w[10:4] = raw[10:4];
            if (cls == 3'd2 || cls == 3'd3) w[3:2] = raw[3:2];
            if (cls == 3'd1 || cls == 3'd2) w[1:0] = raw[1:0];
        end
        return w;
    endfunction

    function automatic string class_tag(logic [2:0] cls, logic bub);
        if (bub) return "R9";
        case (cls)
            3'd1:    return "R5";
            3'd2:    return "R6";
            3'd3:    return "R7";
            3'd4:    return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(string tag, logic [6:0] act, logic [6:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_outputs();
        chk({"R2/", t1}, {ex_alu_op, ex_src_a, ex_src_b, ex_dst_sel}, e1[10:4]);
        chk({"R3/", t2}, {5'd0, mem_we, mem_addr_sel}, {5'd0, e2[3:2]});
        chk({"R4/", t3}, {5'd0, wb_mem_to_reg, wb_reg_we}, {5'd0, e3[1:0]});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs after reset edges
        check_outputs();
        rst = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            logic [10:0] raw;
            logic [2:0]  cls;
            logic        bub;
            @(negedge clk);
            check_outputs();
            raw = (i < 16) ? 11'h7FF : 11'((i * 37 + 11) % 2048);
            cls = 3'(i % 8);
            bub = (i % 5 == 4) || (i >= 16 && i < 24);
            {d_alu_op, d_src_a, d_src_b, d_dst_sel,
             d_mem_we, d_addr_sel, d_mem_to_reg, d_reg_we} = raw;
            d_class  = cls;
            d_bubble = bub;
            if (i == RESET_SLOT) begin
                rst = 1'b1;
                e1 = '0; e2 = '0; e3 = '0;
                t1 = "R1"; t2 = "R1"; t3 = "R1";
            end else begin
                rst = 1'b0;
                e3 = e2; t3 = t2;
                e2 = e1; t2 = t1;
                e1 = expect_word(cls, bub, raw);
                t1 = class_tag(cls, bub);
            end
        end
        // drain with bubbles so the last slots reach writeback
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check_outputs();
            rst = 1'b0;
            d_bubble = 1'b1;
            e3 = e2; t3 = t2;
            e2 = e1; t2 = t1;
            e1 = '0; t1 = "R9";
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule